// File: doc/BRIEF.md
# 24-bit Three-Wire Serial Register Master

This block gives on-chip logic a simple request/response view of an external device whose configuration registers sit behind a three-wire serial link made of 24-bit frames. A caller presents an 8-bit register number, a direction and, for writes, a 16-bit value. The block turns that into two frames, clocks them out one bit at a time with chip select framing each one, and reports the 16-bit result of a read.

Each frame opens with a fixed command byte. The first frame of every access selects the register. The second frame either carries the write value or requests read data, which the device returns during the last 16 bit times of that frame. Half-bit time and chip-select guard time are parameters counted in system clocks. A parameter says whether a return data line is fitted. Without one, reads still complete and return zero.

Top module: `spi24_reg_master`

## Requirements
- R1: Every frame carries exactly 24 bits on spi_mosi_o, most significant bit first. Each bit is held for two half-bit periods of HALF_CNT clocks each.
- R2: The first frame of every access is 0x70 in bits 23:16, 0x00 in bits 15:8 and the register number in bits 7:0.
- R3: For a write, the second frame is 0x72 in bits 23:16 and the write value in bits 15:0.
- R4: For a read, the second frame is 0x730000. rd_data_o takes the last 16 bits sampled from spi_miso_i during that frame, first-sampled bit as bit 15, and holds them until the next read finishes.
- R5: Each bit starts with spi_sck_o low for HALF_CNT clocks while the bit is driven. spi_miso_i is sampled on the last of those clocks. spi_sck_o is then high for HALF_CNT clocks.
- R6: Chip select (active low) falls GAP_CNT clocks before the first SCK low phase. It stays low for GAP_CNT clocks after the last SCK high phase.
- R7: Chip select goes high for GAP_CNT clocks after each frame, including between the two frames of an access. One access lasts 2*(3*GAP_CNT+48*HALF_CNT) clocks from the accepting edge.
- R8: With HAS_MISO = 0, a read completes with the same timing and returns 0x0000.
- R9: After reset and whenever idle, spi_cs_no, spi_sck_o and spi_mosi_o are high. spi_mosi_o is also high during the chip-select guard times, and rd_data_o resets to 0.
- R10: busy_o is high from the clock after a request is accepted until the access ends. done_o is then high for exactly one clock, with busy_o low.
- R11: A request while busy_o is high is ignored and leaves the ongoing access unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle |
| req_wr_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | 8 | Register number |
| req_wdata_i | input | 16 | Write value |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rd_data_o | output | 16 | Result of the last read |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock, idles high |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in (unused when HAS_MISO = 0) |

## Verification
The assertions assume that req_i and the request fields change only between clock edges. They also assume that spi_miso_i is stable around the sampling edge, and that the parameters give at least one clock per half-bit and per guard time. The bench changes every input on the falling clock edge. Its slave model holds each return bit constant for a whole bit window. It uses fixed small counts, so every sample point and chip-select edge lands on a known clock.

// File: rtl/spi24_pkg.sv
package spi24_pkg;
  localparam int FRAME_W = 24;
  localparam int RX_W    = 16;
  localparam int ADDR_W  = 8;
  localparam logic [7:0] CMD_ADDR = 8'h70;
  localparam logic [7:0] CMD_WR   = 8'h72;
  localparam logic [7:0] CMD_RD   = 8'h73;

  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_LOW, E_HIGH, E_HOLD, E_RECOV
  } eng_state_e;
endpackage

// File: rtl/spi24_frame_build.sv
module spi24_frame_build
  import spi24_pkg::*;
(
  input  logic              data_phase_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [RX_W-1:0]   wdata_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_comb begin
    if (!data_phase_i)  frame_o = {CMD_ADDR, {(FRAME_W-8-ADDR_W){1'b0}}, addr_i};
    else if (wr_i)      frame_o = {CMD_WR, wdata_i};
    else                frame_o = {CMD_RD, {RX_W{1'b0}}};
  end
endmodule

// File: rtl/spi24_shift_engine.sv
module spi24_shift_engine
  import spi24_pkg::*;
#(
  parameter int HALF_CNT = 2,
  parameter int GAP_CNT  = 4,
  parameter bit HAS_MISO = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               frame_done_o,
  output logic [RX_W-1:0]    rx_o,
  output logic               cs_n_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int MAXC  = (HALF_CNT > GAP_CNT) ? HALF_CNT : GAP_CNT;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF_CNT - 1);
  localparam logic [CNT_W-1:0] GAP_M1  = CNT_W'(GAP_CNT - 1);

  eng_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_q;
  logic [RX_W-1:0]    rx_q;
  logic               last;
  logic               miso_s;

  generate
    if (HAS_MISO) begin : g_miso
      assign miso_s = miso_i;
    end else begin : g_nomiso
      assign miso_s = 1'b0;
    end
  endgenerate

  always_comb begin
    case (state_q)
      E_LOW, E_HIGH:            last = (cnt_q == HALF_M1);
      E_SETUP, E_HOLD, E_RECOV: last = (cnt_q == GAP_M1);
      default:                  last = 1'b1;
    endcase
  end

  assign frame_done_o = (state_q == E_RECOV) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      case (state_q)
        E_IDLE: begin
          cnt_q <= '0;
          if (start_i) begin
            state_q <= E_SETUP;
            tx_q    <= frame_i;
            bit_q   <= BIT_W'(FRAME_W - 1);
          end
        end
        E_SETUP: if (last) state_q <= E_LOW;
        E_LOW: if (last) begin
          state_q <= E_HIGH;
          rx_q    <= {rx_q[RX_W-2:0], miso_s};
        end
        E_HIGH: if (last) begin
          if (bit_q == '0) state_q <= E_HOLD;
          else begin
            bit_q   <= bit_q - 1'b1;
            state_q <= E_LOW;
          end
        end
        E_HOLD: if (last) state_q <= E_RECOV;
        E_RECOV: if (last) begin
          if (start_i) begin
            state_q <= E_SETUP;
            tx_q    <= frame_i;
            bit_q   <= BIT_W'(FRAME_W - 1);
          end else state_q <= E_IDLE;
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  assign cs_n_o = (state_q == E_IDLE) || (state_q == E_RECOV);
  assign sck_o  = (state_q != E_LOW);
  assign mosi_o = (state_q == E_LOW || state_q == E_HIGH) ? tx_q[bit_q] : 1'b1;
  assign rx_o   = rx_q;

  p_sck_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_o |-> !cs_n_o);
  p_idle_lines_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (sck_o && mosi_o));
  p_cs_rise_after_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> $past(sck_o) && $past(mosi_o));
endmodule

// File: rtl/spi24_reg_master.sv
module spi24_reg_master
  import spi24_pkg::*;
#(
  parameter int HALF_CNT = 2,
  parameter int GAP_CNT  = 4,
  parameter bit HAS_MISO = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        req_wr_i,
  input  logic [7:0]  req_addr_i,
  input  logic [15:0] req_wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rd_data_o,
  output logic        spi_cs_no,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  logic              busy_q, phase_q, wr_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RX_W-1:0]   wdata_q, rd_q, rx;
  logic              accept, frame_done, start;
  logic [FRAME_W-1:0] frame;

  assign accept = req_i && !busy_q;
  assign start  = accept || (busy_q && !phase_q && frame_done);

  spi24_frame_build u_build (
    .data_phase_i (!accept),
    .wr_i         (wr_q),
    .addr_i       (req_addr_i),
    .wdata_i      (wdata_q),
    .frame_o      (frame)
  );

  spi24_shift_engine #(
    .HALF_CNT (HALF_CNT),
    .GAP_CNT  (GAP_CNT),
    .HAS_MISO (HAS_MISO)
  ) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .frame_i      (frame),
    .frame_done_o (frame_done),
    .rx_o         (rx),
    .cs_n_o       (spi_cs_no),
    .sck_o        (spi_sck_o),
    .mosi_o       (spi_mosi_o),
    .miso_i       (spi_miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        wr_q    <= req_wr_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end else if (busy_q && frame_done) begin
        if (!phase_q) phase_q <= 1'b1;
        else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (!wr_q) rd_q <= rx;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rd_data_o = rd_q;

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_not_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_busy_end_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));
  p_cs_between_frames_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && frame_done) |-> spi_cs_no);
endmodule

// File: tb/spi24_reg_master_tb.sv
module spi24_reg_master_tb;
  localparam int HALF = 2;
  localparam int GAP  = 4;
  localparam int F    = 3*GAP + 48*HALF;
  localparam int T    = 2*F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic miso = 1'b1;
  logic busy, done, cs_n, sck, mosi;
  logic [15:0] rd;
  logic busy2, done2, cs_n2, sck2, mosi2;
  logic [15:0] rd2;

  always #10 clk = ~clk;

  spi24_reg_master #(.HALF_CNT(HALF), .GAP_CNT(GAP), .HAS_MISO(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(wr), .req_addr_i(addr),
    .req_wdata_i(wdata), .busy_o(busy), .done_o(done), .rd_data_o(rd),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso));

  spi24_reg_master #(.HALF_CNT(HALF), .GAP_CNT(GAP), .HAS_MISO(1'b0)) u_dut_nr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(wr), .req_addr_i(addr),
    .req_wdata_i(wdata), .busy_o(busy2), .done_o(done2), .rd_data_o(rd2),
    .spi_cs_no(cs_n2), .spi_sck_o(sck2), .spi_mosi_o(mosi2), .spi_miso_i(miso));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit m_act = 0, m_wr = 0, e_done = 0, ign = 0;
  int m_k = 0;
  logic [7:0]  m_addr = '0;
  logic [15:0] m_data = '0, e_rd = '0, e_rd2 = '0;
  logic [23:0] slave_word = 24'hFFFFFF;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s%s actual=%0h expected=%0h at %0t", tag, ign ? " (R11 window)" : "", act, exp, $time);
    end
  endtask

  // reference model: advances at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; e_done = 0; e_rd = '0; e_rd2 = '0;
    end else begin
      e_done = 0;
      if (m_act) begin
        m_k++;
        if (m_k == T) begin
          m_act = 0; e_done = 1;
          if (!m_wr) begin e_rd = slave_word[15:0]; e_rd2 = '0; end
        end
      end else if (req) begin
        m_act = 1; m_k = 0; m_wr = wr; m_addr = addr; m_data = wdata;
      end
    end
  end

  always @(negedge clk) begin
    logic e_cs, e_sck, e_mosi;
    logic [23:0] fw;
    int t, fr, b;
    string mtag, ctag;
    e_cs = 1; e_sck = 1; e_mosi = 1; b = -1; mtag = "R9 mosi"; ctag = "R9 cs";
    if (m_act) begin
      fr = m_k / F; t = m_k % F;
      fw = (fr == 0) ? {8'h70, 8'h00, m_addr} : (m_wr ? {8'h72, m_data} : 24'h730000);
      mtag = (fr == 0) ? "R1/R2 mosi" : (m_wr ? "R1/R3 mosi" : "R1/R4 mosi");
      ctag = "R6 cs";
      if (t < GAP) e_cs = 0;
      else if (t < GAP + 48*HALF) begin
        e_cs = 0;
        b = (t - GAP) / (2*HALF);
        e_sck = ((t - GAP) % (2*HALF)) >= HALF;
        e_mosi = fw[23-b];
      end else if (t < 2*GAP + 48*HALF) e_cs = 0;
      else ctag = "R7 cs";
    end
    chk(ctag, cs_n, e_cs);
    chk("R5 sck", sck, e_sck);
    chk(mtag, mosi, e_mosi);
    chk("R10 busy", busy, m_act);
    chk("R10 done", done, e_done);
    chk("R4 rd_data", rd, e_rd);
    chk("R8 cs", cs_n2, e_cs);
    chk("R8 done", done2, e_done);
    chk("R8 rd_data", rd2, e_rd2);
    miso <= (b >= 0) ? slave_word[23-b] : 1'b1;
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic access(input logic w, input logic [7:0] a, input logic [15:0] d, input logic [23:0] s);
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; slave_word = s;
    @(negedge clk);
    req = 0;
    repeat (T + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    access(1, 8'hB7, 16'h0301, 24'h000000);  // R3
    access(0, 8'hB0, 16'h0000, 24'h5A2828);  // R4
    access(0, 8'hC6, 16'h1234, 24'h00A5C3);  // R4, R8
    access(1, 8'h5F, 16'hFFFF, 24'hFFFFFF);  // R1 all ones
    access(1, 8'h00, 16'h0000, 24'h0F0F0F);  // R2 zero register
    access(0, 8'hFF, 16'h0000, 24'hFFFFFF);  // R4 all ones back
    // R11: a second request during an access is ignored
    @(negedge clk);
    req = 1; wr = 0; addr = 8'hD5; slave_word = 24'h3C6699;
    @(negedge clk);
    req = 0;
    repeat (30) @(negedge clk);
    ign = 1;
    req = 1; wr = 1; addr = 8'h11; wdata = 16'hBEEF;
    @(negedge clk);
    @(negedge clk);
    req = 0;
    repeat (T) @(negedge clk);
    ign = 0;
    // back-to-back: request held high across completion
    @(negedge clk);
    req = 1; wr = 0; addr = 8'hB1; slave_word = 24'h81C3E7;
    repeat (T + 6) @(negedge clk);
    req = 0;
    repeat (T + 4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule